// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds five pulse-width timers that share one control word on a simple register bus. Each timer owns two staging registers, a period value and a threshold value, which software may rewrite at any time. A down-counter and a working threshold copy these staging values only on a manual load or, when periodic reload is on, when the counter underflows. Between loads, staged writes do not touch the running waveform.

Each timer decrements once per cycle in which its tick enable, supplied by an external prescaler, is high. Its output is active while the counter is at or below the working threshold. An optional inverter sits on the output of every timer but the last. Each timer also raises a one-cycle underflow pulse. Software starts a timer in two writes. The first sets the manual-load bit with start clear. The second clears manual load and sets start together with reload. Clearing reload lets the current period run out, after which the timer halts.

The control word packs four bits per timer. Timer 0 uses bits 3:0. Timer n (n ≥ 1) uses bits 4n+7:4n+4, so bits 7:4 are never used. Inside a group, bit 0 is start, bit 1 is manual load, bit 2 is invert and bit 3 is reload. The last timer has no inverter, and its reload bit sits at bit 2 of its group.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every register reads zero, every PWM output is low and no underflow pulse is raised.
- R2: The control word is at byte address 0x08. Timer n's period staging register is at 0x0C + 12·n and its threshold staging register at 0x10 + 12·n. Staging registers read back the low CNT_W bits written. Any other address reads zero and ignores writes.
- R3: Timer 0 owns control bits 3:0 and timer n ≥ 1 owns bits 4n+7:4n+4, with start, manual load, invert and reload at group bits 0, 1, 2, 3. Bits 7:4 and bits above the last group read zero.
- R4: For the last timer, reload is at group bit 2 and there is no invert bit; group bit 3 reads zero, and reload at bit 2 keeps that timer periodic.
- R5: While manual load is set, the counter and threshold copy the staging registers on every clock and ticks do not decrement.
- R6: With start set, each tick decrements the counter. With reload set, a period value N repeats every N+1 ticks, and the cycle after the tick that finds the counter at zero carries a one-cycle underflow pulse.
- R7: The un-inverted output is high while the counter is at or below the threshold; a threshold of all ones gives a constantly high output.
- R8: With invert set, the output is the complement, and its idle level is high.
- R9: While start is clear, the counter holds its value and the output sits at its idle level; setting start again resumes from the held count.
- R10: With reload clear, the timer completes its period, raises its underflow pulse and then halts with the output idle and no further pulses until a manual load.
- R11: A staging write during a running period takes effect only at the next reload.
- R12: A cycle with the tick enable low changes neither the output nor the underflow line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | NUM_CH | Per-timer count enable from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for write and read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | PWM outputs |
| underflow | output | NUM_CH | One-cycle underflow pulses |

## Verification
A register write is captured on the rising edge that sees bus_wr. Its read-back is due straight after that edge, and a new control bit such as start or invert reaches the outputs in the same cycle. A manual load moves the staging values into the counter on the next edge after the manual bit is captured. The PWM output follows the count right after each tick edge. The underflow pulse is high for exactly the cycle after the tick edge that found zero. The bench drives every input on the falling edge, lets exactly one rising edge pass per step, and compares outputs at the next falling edge against values worked out tick by tick from the requirements.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int unsigned CTRL_ADDR   = 8;
  localparam int unsigned BUF_BASE    = 12;
  localparam int unsigned BUF_STRIDE  = 12;
  localparam int unsigned THR_OFFSET  = 4;
  localparam int unsigned GROUP_W     = 4;

  // bit positions inside a timer's control group
  localparam int unsigned BIT_START   = 0;
  localparam int unsigned BIT_MANUAL  = 1;
  localparam int unsigned BIT_INVERT  = 2;
  localparam int unsigned BIT_RELOAD  = 3;
  localparam int unsigned BIT_RELOAD_LAST = 2;

  typedef struct packed {
    logic start;
    logic manual;
    logic invert;
    logic reload;
  } chan_ctl_t;

  // group 1 is skipped: timer 0 -> group 0, timer n -> group n+1
  function automatic int unsigned group_lsb(input int unsigned ch);
    return (ch == 0) ? 0 : GROUP_W * (ch + 1);
  endfunction

  function automatic int unsigned period_addr(input int unsigned ch);
    return BUF_BASE + BUF_STRIDE * ch;
  endfunction

  function automatic int unsigned thresh_addr(input int unsigned ch);
    return BUF_BASE + BUF_STRIDE * ch + THR_OFFSET;
  endfunction

endpackage

// File: rtl/pwm_bank_rst_sync.sv
module pwm_bank_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  output chan_ctl_t [NUM_CH-1:0]         ctl,
  output logic [NUM_CH-1:0][CNT_W-1:0]   period_buf,
  output logic [NUM_CH-1:0][CNT_W-1:0]   thresh_buf
);

  function automatic logic [DATA_W-1:0] build_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (c == NUM_CH - 1) begin
        m[group_lsb(c) + BIT_START]       = 1'b1;
        m[group_lsb(c) + BIT_MANUAL]      = 1'b1;
        m[group_lsb(c) + BIT_RELOAD_LAST] = 1'b1;
      end else begin
        m[group_lsb(c) + BIT_START]  = 1'b1;
        m[group_lsb(c) + BIT_MANUAL] = 1'b1;
        m[group_lsb(c) + BIT_INVERT] = 1'b1;
        m[group_lsb(c) + BIT_RELOAD] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = build_mask();
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_we;

  always_comb begin
    ctrl_we = bus_wr && (bus_addr == CTRL_A);
    ctrl_d  = bus_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam int unsigned LSB = group_lsb(ch);
    localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(period_addr(ch));
    localparam logic [ADDR_W-1:0] THR_A = ADDR_W'(thresh_addr(ch));

    logic per_we;
    logic thr_we;
    logic [CNT_W-1:0] stage_d;

    assign ctl[ch].start  = ctrl_q[LSB + BIT_START];
    assign ctl[ch].manual = ctrl_q[LSB + BIT_MANUAL];

    if (ch == NUM_CH - 1) begin : g_last
      assign ctl[ch].invert = 1'b0;
      assign ctl[ch].reload = ctrl_q[LSB + BIT_RELOAD_LAST];
    end else begin : g_std
      assign ctl[ch].invert = ctrl_q[LSB + BIT_INVERT];
      assign ctl[ch].reload = ctrl_q[LSB + BIT_RELOAD];
    end

    always_comb begin
      per_we  = bus_wr && (bus_addr == PER_A);
      thr_we  = bus_wr && (bus_addr == THR_A);
      stage_d = bus_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        period_buf[ch] <= '0;
      end else if (per_we) begin
        period_buf[ch] <= stage_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thresh_buf[ch] <= '0;
      end else if (thr_we) begin
        thresh_buf[ch] <= stage_d;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_A) begin
      bus_rdata = ctrl_q;
    end
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(period_addr(c))) begin
        bus_rdata = DATA_W'(period_buf[c]);
      end
      if (bus_addr == ADDR_W'(thresh_addr(c))) begin
        bus_rdata = DATA_W'(thresh_buf[c]);
      end
    end
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  chan_ctl_t        ctl,
  input  logic [CNT_W-1:0] period_buf,
  input  logic [CNT_W-1:0] thresh_buf,
  output logic             pwm,
  output logic             uf_pulse,
  output logic [CNT_W-1:0] cnt_val,
  output logic             halted
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] thr_q;
  logic             cnt_en, thr_en;
  logic             halt_q, halt_d, halt_en;
  logic             uf_q, uf_d;
  logic             run, at_zero, counting, wrap, load, step, stop;

  always_comb begin
    run      = ctl.start & ~halt_q;
    at_zero  = (cnt_q == '0);
    counting = ~ctl.manual & run & tick;
    wrap     = counting & at_zero;
    step     = counting & ~at_zero;
    load     = ctl.manual | (wrap & ctl.reload);
    stop     = wrap & ~ctl.reload;

    cnt_en   = load | step;
    cnt_d    = load ? period_buf : (cnt_q - CNT_W'(1));
    thr_en   = load;

    halt_en  = ctl.manual | stop;
    halt_d   = ~ctl.manual;

    uf_d     = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_en) begin
      thr_q <= thresh_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (halt_en) begin
      halt_q <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
    end else begin
      uf_q <= uf_d;
    end
  end

  assign pwm      = (run & (cnt_q <= thr_q)) ^ ctl.invert;
  assign uf_pulse = uf_q;
  assign cnt_val  = cnt_q;
  assign halted   = halt_q;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [NUM_CH-1:0] underflow
);

  logic                          rst_int_n;
  chan_ctl_t [NUM_CH-1:0]        ctl;
  logic [NUM_CH-1:0][CNT_W-1:0]  period_buf;
  logic [NUM_CH-1:0][CNT_W-1:0]  thresh_buf;
  logic [NUM_CH-1:0][CNT_W-1:0]  chan_cnt;
  logic [NUM_CH-1:0]             chan_halt;
  logic [NUM_CH-1:0]             chan_start;
  logic [NUM_CH-1:0]             chan_manual;
  logic [NUM_CH-1:0]             chan_invert;

  pwm_bank_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwm_bank_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctl        (ctl),
    .period_buf (period_buf),
    .thresh_buf (thresh_buf)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tmr
    pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .tick       (tick_en[ch]),
      .ctl        (ctl[ch]),
      .period_buf (period_buf[ch]),
      .thresh_buf (thresh_buf[ch]),
      .pwm        (pwm_out[ch]),
      .uf_pulse   (underflow[ch]),
      .cnt_val    (chan_cnt[ch]),
      .halted     (chan_halt[ch])
    );
    assign chan_start[ch]  = ctl[ch].start;
    assign chan_manual[ch] = ctl[ch].manual;
    assign chan_invert[ch] = ctl[ch].invert;
  end

endmodule

// File: rtl/pwm_timer_bank_chk.sv
module pwm_timer_bank_chk #(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            tick_en,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            underflow,
  input logic [NUM_CH-1:0][CNT_W-1:0] chan_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] period_buf,
  input logic [NUM_CH-1:0]            chan_halt,
  input logic [NUM_CH-1:0]            chan_start,
  input logic [NUM_CH-1:0]            chan_manual,
  input logic [NUM_CH-1:0]            chan_invert
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_p
    // R5: manual load copies the staging period on the next edge
    a_r5_manual_load: assert property (@(posedge clk) disable iff (!rst_n)
      chan_manual[ch] |=> (chan_cnt[ch] == $past(period_buf[ch])));

    // R6: a running tick at nonzero count decrements by one
    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_start[ch] && !chan_manual[ch] && !chan_halt[ch] && tick_en[ch]
       && (chan_cnt[ch] != '0))
      |=> (chan_cnt[ch] == $past(chan_cnt[ch]) - CNT_W'(1)));

    // R6: an underflow pulse always follows a tick
    a_r6_uf_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      underflow[ch] |-> $past(tick_en[ch]));

    // R9: stopped timer keeps its count
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_start[ch] && !chan_manual[ch]) |=> $stable(chan_cnt[ch]));

    // R8: idle output level follows the invert bit
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_start[ch] |-> (pwm_out[ch] == chan_invert[ch]));

    // R10: a halted timer raises no further underflow
    a_r10_no_pulse_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_halt[ch] && !chan_manual[ch]) |=> !underflow[ch]);

    // R12: no tick, no manual load: count unchanged
    a_r12_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en[ch] && !chan_manual[ch]) |=> $stable(chan_cnt[ch]));
  end

endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .pwm_out     (pwm_out),
  .underflow   (underflow),
  .chan_cnt    (chan_cnt),
  .period_buf  (period_buf),
  .chan_halt   (chan_halt),
  .chan_start  (chan_start),
  .chan_manual (chan_manual),
  .chan_invert (chan_invert)
);

// File: tb/pwm_timer_bank_tb.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb;

  localparam int NCH = 5;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{8'h08, 32'hFFFF_FFFF, 32'h007F_FF0F},
    '{8'h0C, 32'h1234_ABCD, 32'h0000_ABCD},
    '{8'h10, 32'h0000_5555, 32'h0000_5555},
    '{8'h18, 32'h0000_0101, 32'h0000_0101},
    '{8'h1C, 32'h0000_0202, 32'h0000_0202},
    '{8'h24, 32'h0000_0303, 32'h0000_0303},
    '{8'h28, 32'h0000_0404, 32'h0000_0404},
    '{8'h30, 32'h0000_0505, 32'h0000_0505},
    '{8'h34, 32'h0000_0606, 32'h0000_0606},
    '{8'h3C, 32'h0000_0707, 32'h0000_0707},
    '{8'h40, 32'hFFFF_0808, 32'h0000_0808},
    '{8'h14, 32'h0000_FFFF, 32'h0000_0000},
    '{8'h08, 32'h0000_0F00, 32'h0000_0F00},
    '{8'h08, 32'h0000_00F0, 32'h0000_0000},
    '{8'h08, 32'h0080_0000, 32'h0000_0000},
    '{8'h08, 32'h0000_0000, 32'h0000_0000}
  };

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] tick_en;
  logic           bus_wr;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic [NCH-1:0] underflow;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  pwm_timer_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .underflow (underflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // all tasks begin and end on a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick_chk(input int ch, input logic eo, input logic eu,
                          input string req);
    tick_en = '0;
    tick_en[ch] = 1'b1;
    @(negedge clk);
    tick_en = '0;
    chk(pwm_out[ch] == eo, {req, " out"}, 32'(pwm_out[ch]), 32'(eo));
    chk(underflow[ch] == eu, {req, " underflow"}, 32'(underflow[ch]), 32'(eu));
  endtask

  task automatic idle_chk(input int ch, input logic eo, input string req);
    @(negedge clk);
    chk(pwm_out[ch] == eo, {req, " out"}, 32'(pwm_out[ch]), 32'(eo));
    chk(underflow[ch] == 1'b0, {req, " underflow"}, 32'(underflow[ch]), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; tick_en = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(pwm_out == '0, "R1 pwm_out", 32'(pwm_out), 32'd0);
    chk(underflow == '0, "R1 underflow", 32'(underflow), 32'd0);
    rd(8'h08, d); chk(d == 32'd0, "R1 control", d, 32'd0);
    rd(8'h3C, d); chk(d == 32'd0, "R1 staging", d, 32'd0);

    // R2 R3 R4: register map walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].addr, VEC[i].wdata);
      rd(VEC[i].addr, d);
      chk(d == VEC[i].expv, $sformatf("R2 R3 R4 vector %0d", i), d, VEC[i].expv);
    end

    // R6 R7: timer 1, period 3, threshold 1, periodic
    wr(8'h18, 32'd3);
    wr(8'h1C, 32'd1);
    wr(8'h08, 32'h0000_0200);
    wr(8'h08, 32'h0000_0900);
    for (int k = 1; k <= 8; k++) begin
      int c;
      c = 3 - (k % 4);
      tick_chk(1, (c <= 1), ((k % 4) == 0), "R6 R7 periodic");
    end
    // R12: no tick, nothing moves (count 3)
    idle_chk(1, 1'b0, "R12 no tick");
    tick_chk(1, 1'b0, 1'b0, "R6 count 2");
    tick_chk(1, 1'b1, 1'b0, "R6 count 1");
    idle_chk(1, 1'b1, "R12 no tick");

    // R9: clear start, count held at 1
    wr(8'h08, 32'h0000_0800);
    chk(pwm_out[1] == 1'b0, "R9 idle", 32'(pwm_out[1]), 32'd0);
    for (int k = 0; k < 3; k++) tick_chk(1, 1'b0, 1'b0, "R9 stopped ticks");
    wr(8'h08, 32'h0000_0900);
    chk(pwm_out[1] == 1'b1, "R9 resume held count", 32'(pwm_out[1]), 32'd1);
    tick_chk(1, 1'b1, 1'b0, "R9 count 0");
    tick_chk(1, 1'b0, 1'b1, "R9 reload");

    // R11: change period mid-run; next underflow after 4 ticks, then 6
    wr(8'h18, 32'd5);
    for (int k = 1; k <= 10; k++) begin
      logic eo;
      eo = (k == 2) || (k == 3) || (k == 8) || (k == 9);
      tick_chk(1, eo, (k == 4) || (k == 10), "R11 staged period");
    end

    // R8: invert (count 5, threshold 1: raw low)
    wr(8'h08, 32'h0000_0D00);
    chk(pwm_out[1] == 1'b1, "R8 inverted", 32'(pwm_out[1]), 32'd1);
    wr(8'h08, 32'h0000_0C00);
    chk(pwm_out[1] == 1'b1, "R8 idle high", 32'(pwm_out[1]), 32'd1);

    // R10: timer 2 one-shot, period 2, threshold 0
    wr(8'h24, 32'd2);
    wr(8'h28, 32'd0);
    wr(8'h08, 32'h0000_2000);
    wr(8'h08, 32'h0000_1000);
    for (int k = 1; k <= 6; k++)
      tick_chk(2, (k == 2), (k == 3), "R10 one-shot");

    // R5: timer 0 manual load held with start and ticks
    wr(8'h0C, 32'd4);
    wr(8'h10, 32'd2);
    wr(8'h08, 32'h0000_0003);
    for (int k = 0; k < 3; k++) tick_chk(0, 1'b0, 1'b0, "R5 manual held");
    wr(8'h08, 32'h0000_0009);
    tick_chk(0, 1'b0, 1'b0, "R5 count 3");
    tick_chk(0, 1'b1, 1'b0, "R5 count 2");
    tick_chk(0, 1'b1, 1'b0, "R5 count 1");
    tick_chk(0, 1'b1, 1'b0, "R5 count 0");
    tick_chk(0, 1'b0, 1'b1, "R5 reload");

    // R7: all-ones threshold gives constant high
    wr(8'h10, 32'h0000_FFFF);
    wr(8'h08, 32'h0000_0002);
    wr(8'h08, 32'h0000_0009);
    for (int k = 1; k <= 10; k++)
      tick_chk(0, 1'b1, (k == 5) || (k == 10), "R7 full duty");

    // R4: last timer reload at group bit 2
    wr(8'h3C, 32'd1);
    wr(8'h40, 32'd0);
    wr(8'h08, 32'h0020_0000);
    wr(8'h08, 32'h0050_0000);
    for (int k = 1; k <= 4; k++)
      tick_chk(4, (k % 2) == 1, (k % 2) == 0, "R4 last timer periodic");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule